// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides when the output drivers of a memory interface may take new impedance codes. An external calibration comparator supplies a fresh pull-up code and a fresh pull-down code all the time. The scheduler holds the two codes that the drivers actually use. It replaces them only when doing so cannot disturb an output that is switching. Read cycles keep the data drivers busy, so a refresh is allowed only after a long unbroken run of write or idle cycles. The echo-clock drivers toggle on every clock. Because of that, each half of the driver may only be recoded while the echo clock is driving the opposite level, which leaves that half idle.

Each cycle the bus controller reports the operation kind, and the echo-clock generator reports its current output level. The scheduler counts consecutive non-read cycles. At the first cycle of each run it samples the comparator codes into a shadow register. When the run reaches its full length, it arms both halves. Each armed half then commits its staged code, with a one-cycle strobe, at the first non-read cycle whose echo level matches that half. Separately, a sticky flag shows when enough non-read cycles have passed since reset for the power-up calibration to have settled.

Top module: `zq_sched`

## Requirements
- R1: `op_kind` value 2'b01 marks a read. Every other value (2'b00 idle, 2'b10 write, 2'b11) is a non-read cycle. A read restarts the run count. The edge that ends the PERIOD-th consecutive non-read cycle (64 by default) arms both halves, and no earlier edge does.
- R2: A half never commits at the edge ending a read cycle. An armed half stays armed across any number of read cycles.
- R3: The pull-down code commits only at an edge ending a non-read cycle in which `echo_hi` is 1.
- R4: The pull-up code commits only at an edge ending a non-read cycle in which `echo_hi` is 0.
- R5: A strobe is high for exactly one cycle per arming. It appears in the cycle right after its commit edge, together with the new code. An active code never changes while its strobe is low.
- R6: The committed value is the comparator code present in the first non-read cycle of the run that armed the half. Later changes of the comparator code within that run have no effect on it.
- R7: `cal_done` rises after CAL_CYCLES non-read cycles (2048 by default) have been counted since reset. Reads pause this count but do not clear it. Once high, `cal_done` stays high until reset.
- R8: While `rst` is high and right after it, both active codes equal RST_CODE (32 by default), both strobes are 0 and `cal_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Operation kind this cycle (2'b01 read, others non-read) |
| echo_hi | input | 1 | Echo-clock output level this cycle |
| pu_code_in | input | W | Pull-up code from the comparator |
| pd_code_in | input | W | Pull-down code from the comparator |
| pu_code | output | W | Active pull-up code |
| pd_code | output | W | Active pull-down code |
| pu_upd | output | 1 | One-cycle pull-up commit strobe |
| pd_upd | output | 1 | One-cycle pull-down commit strobe |
| cal_done | output | 1 | Power-up calibration period complete |

## Verification
Each result becomes visible in the cycle after the edge that ends the input cycle causing it. Arming happens at the edge ending the 64th non-read cycle, so the earliest strobe shows up one cycle after the 65th. `cal_done` shows up right after the edge ending the 2048th non-read cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Every expected strobe is therefore tied to the exact input cycle, counted from the reset or from the last read.

// File: rtl/zq_pkg.sv
package zq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  function automatic logic is_nonread(input logic [1:0] op);
    return op != OP_RD;
  endfunction
endpackage

// File: rtl/zq_run_counter.sv
module zq_run_counter #(
  parameter int PERIOD = 64,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic nonread,
  output logic cap,
  output logic arm
);
  logic [CW-1:0] cnt_q;

  // first non-read cycle of a run, and the last one of a full run
  assign cap = nonread && (cnt_q == '0);
  assign arm = nonread && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!nonread || arm) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/zq_half.sv
module zq_half #(
  parameter int W        = 6,
  parameter int RST_CODE = 32,
  parameter bit FIRE_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         arm,
  input  logic         nonread,
  input  logic         echo_hi,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code,
  output logic         upd
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] stage_q;
  logic         pend_q;
  logic         fire;

  // commit only when this half is idle: the echo driver holds the other level
  assign fire = pend_q && nonread && (echo_hi == FIRE_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= W'(RST_CODE);
      stage_q  <= W'(RST_CODE);
      pend_q   <= 1'b0;
      code     <= W'(RST_CODE);
      upd      <= 1'b0;
    end else begin
      if (cap) shadow_q <= code_in;
      if (arm) stage_q  <= shadow_q;
      pend_q <= arm || (pend_q && !fire);
      if (fire) code <= stage_q;
      upd <= fire;
    end
  end
endmodule

// File: rtl/zq_cal_tracker.sv
module zq_cal_tracker #(
  parameter int CAL_CYCLES = 2048,
  localparam int KW = $clog2(CAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic nonread,
  output logic done
);
  logic [KW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      done   <= 1'b0;
    end else if (nonread && !done) begin
      seen_q <= seen_q + 1'b1;
      if (seen_q == KW'(CAL_CYCLES - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/zq_sched.sv
module zq_sched #(
  parameter int W          = 6,
  parameter int PERIOD     = 64,
  parameter int CAL_CYCLES = 2048,
  parameter int RST_CODE   = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_kind,
  input  logic         echo_hi,
  input  logic [W-1:0] pu_code_in,
  input  logic [W-1:0] pd_code_in,
  output logic [W-1:0] pu_code,
  output logic [W-1:0] pd_code,
  output logic         pu_upd,
  output logic         pd_upd,
  output logic         cal_done
);
  import zq_pkg::*;

  localparam int NHALF = 2;  // index 0 pull-up, index 1 pull-down

  logic         nonread;
  logic         cap;
  logic         arm;
  logic [W-1:0] code_in_a [NHALF];
  logic [W-1:0] code_a    [NHALF];
  logic         upd_a     [NHALF];

  assign nonread      = is_nonread(op_kind);
  assign code_in_a[0] = pu_code_in;
  assign code_in_a[1] = pd_code_in;

  zq_run_counter #(.PERIOD(PERIOD)) u_run (
    .clk    (clk),
    .rst    (rst),
    .nonread(nonread),
    .cap    (cap),
    .arm    (arm)
  );

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    // pull-up recodes while echo is low, pull-down while echo is high
    zq_half #(
      .W       (W),
      .RST_CODE(RST_CODE),
      .FIRE_LVL(g == 1)
    ) u_half (
      .clk    (clk),
      .rst    (rst),
      .cap    (cap),
      .arm    (arm),
      .nonread(nonread),
      .echo_hi(echo_hi),
      .code_in(code_in_a[g]),
      .code   (code_a[g]),
      .upd    (upd_a[g])
    );
  end

  zq_cal_tracker #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk    (clk),
    .rst    (rst),
    .nonread(nonread),
    .done   (cal_done)
  );

  assign pu_code = code_a[0];
  assign pd_code = code_a[1];
  assign pu_upd  = upd_a[0];
  assign pd_upd  = upd_a[1];
endmodule

// File: rtl/zq_sched_chk.sv
module zq_sched_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_kind,
  input logic         echo_hi,
  input logic [W-1:0] pu_code,
  input logic [W-1:0] pd_code,
  input logic         pu_upd,
  input logic         pd_upd,
  input logic         cal_done
);
  AST_NO_READ_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b01) |=> (!pu_upd && !pd_upd)); // R2
  AST_PD_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!echo_hi) |=> !pd_upd); // R3
  AST_PU_PHASE: assert property (@(posedge clk) disable iff (rst)
    echo_hi |=> !pu_upd); // R4
  AST_PU_PULSE: assert property (@(posedge clk) disable iff (rst)
    pu_upd |=> !pu_upd); // R5
  AST_PD_PULSE: assert property (@(posedge clk) disable iff (rst)
    pd_upd |=> !pd_upd); // R5
  AST_PU_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pu_upd |-> $stable(pu_code)); // R5
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pd_upd |-> $stable(pd_code)); // R5
  AST_CAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> cal_done); // R7
endmodule

bind zq_sched zq_sched_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_kind (op_kind),
  .echo_hi (echo_hi),
  .pu_code (pu_code),
  .pd_code (pd_code),
  .pu_upd  (pu_upd),
  .pd_upd  (pd_upd),
  .cal_done(cal_done)
);

// File: tb/zq_sched_bench.sv
module zq_sched_bench;
  localparam int CLK_P = 10;
  localparam int W     = 6;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_r = NOP;
  logic         echo_r = 1'b0;
  logic [W-1:0] pu_in = '0;
  logic [W-1:0] pd_in = '0;
  logic [W-1:0] pu_code, pd_code;
  logic         pu_upd, pd_upd, cal_done;
  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  zq_sched u_zq_sched (
    .clk       (clk),
    .rst       (rst),
    .op_kind   (op_r),
    .echo_hi   (echo_r),
    .pu_code_in(pu_in),
    .pd_code_in(pd_in),
    .pu_code   (pu_code),
    .pd_code   (pd_code),
    .pu_upd    (pu_upd),
    .pd_upd    (pd_upd),
    .cal_done  (cal_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic [1:0] op, input logic e);
    op_r   = op;
    echo_r = e;
    @(negedge clk);
  endtask

  task automatic run_nonread(input int n, output int strobes);
    strobes = 0;
    for (int i = 0; i < n; i++) begin
      tick((i % 3 == 0) ? NOP : ((i % 3 == 1) ? WR : RSV), logic'(i % 2));
      strobes += int'(pu_upd) + int'(pd_upd);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(NOP, 1'b0);
    tick(NOP, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 pu_code", pu_code, 32);
    check("R8 pd_code", pd_code, 32);
    check("R8 strobes", int'(pu_upd) + int'(pd_upd), 0);
    check("R8 cal_done", cal_done, 0);
  endtask

  task automatic t_basic();
    int s;
    do_reset();
    pu_in = 6'd5; pd_in = 6'd9;
    tick(NOP, 1'b0);
    pu_in = 6'd1; pd_in = 6'd2;
    run_nonread(63, s);
    check("R5 no strobe before arming", s, 0);
    tick(WR, 1'b1);
    check("R3 pd strobe echo high", pd_upd, 1);
    check("R6 pd code from run start", pd_code, 9);
    check("R4 pu waits for echo low", pu_upd, 0);
    check("R5 pu code unchanged", pu_code, 32);
    tick(NOP, 1'b0);
    check("R4 pu strobe echo low", pu_upd, 1);
    check("R6 pu code from run start", pu_code, 5);
    check("R5 pd strobe single cycle", pd_upd, 0);
    run_nonread(62, s);
    check("R5 no strobe inside second run", s, 0);
    tick(NOP, 1'b1);
    check("R1 second period pd strobe", pd_upd, 1);
    check("R6 second period pd code", pd_code, 2);
  endtask

  task automatic t_read_restart();
    int s;
    do_reset();
    pu_in = 6'd11; pd_in = 6'd12;
    run_nonread(40, s);
    tick(RD, 1'b0);
    run_nonread(63, s);
    check("R1 no strobe after read restart", s, 0);
    tick(NOP, 1'b1);
    check("R1 not armed before 64th edge", pd_upd, 0);
    tick(NOP, 1'b1);
    check("R1 armed after 64 cycles", pd_upd, 1);
    check("R1 pd code", pd_code, 12);
  endtask

  task automatic t_read_blocks();
    int s;
    do_reset();
    pu_in = 6'd17; pd_in = 6'd23;
    run_nonread(64, s);
    tick(RD, 1'b1);
    check("R2 no pd commit on read", pd_upd, 0);
    check("R2 pd code held on read", pd_code, 32);
    tick(RD, 1'b0);
    check("R2 no pu commit on read", pu_upd, 0);
    tick(NOP, 1'b1);
    check("R2 pd pending survives reads", pd_upd, 1);
    check("R2 pd code", pd_code, 23);
    tick(NOP, 1'b0);
    check("R2 pu pending survives reads", pu_upd, 1);
    check("R2 pu code", pu_code, 17);
  endtask

  task automatic t_phase();
    int s;
    do_reset();
    pu_in = 6'd40; pd_in = 6'd41;
    run_nonread(64, s);
    tick(NOP, 1'b0);
    check("R4 pu fires on echo low", pu_upd, 1);
    check("R3 pd blocked on echo low", pd_upd, 0);
    tick(WR, 1'b0);
    check("R5 pu pulse one cycle", pu_upd, 0);
    check("R3 pd still blocked", pd_upd, 0);
    tick(NOP, 1'b0);
    check("R3 pd blocked third cycle", pd_upd, 0);
    check("R5 pd code held", pd_code, 32);
    tick(NOP, 1'b1);
    check("R3 pd fires on echo high", pd_upd, 1);
    check("R3 pd code", pd_code, 41);
  endtask

  task automatic t_cal();
    int s;
    do_reset();
    run_nonread(1000, s);
    check("R7 cal low early", cal_done, 0);
    for (int i = 0; i < 5; i++) tick(RD, logic'(i % 2));
    run_nonread(1047, s);
    check("R7 cal low at 2047", cal_done, 0);
    tick(RD, 1'b0);
    check("R7 read does not count", cal_done, 0);
    tick(WR, 1'b1);
    check("R7 cal high at 2048", cal_done, 1);
    for (int i = 0; i < 3; i++) tick(RD, logic'(i % 2));
    check("R7 cal sticky over reads", cal_done, 1);
    do_reset();
    check("R8 cal cleared by reset", cal_done, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_read_restart();
    t_read_blocks();
    t_phase();
    t_cal();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule